// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Filtering

This block receives asynchronous serial characters on one input line. An outside divider supplies a baud tick at sixteen times the bit rate. On a low level the receiver starts a frame. It checks the start bit again half a bit later, then samples eight or nine data bits at mid-bit, least significant bit first, and then the stop bit. A finished character goes into a two-entry receive buffer together with its ninth bit and a framing status. The buffer head is always visible at the outputs, and a read strobe removes it.

In nine-bit mode an address filter can be switched on. With the filter on, only characters whose ninth bit is 1 reach the buffer, so a station can ignore traffic until it is addressed. With the filter off, every character is stored and the ninth bit is passed through as received, with no parity check. If a character finishes while the buffer is full, a sticky overrun flag is set. The flag blocks further reception until the continuous-receive enable is taken low.

Top module: `addr_uart_rx`

## Requirements
- R1: After reset, data_irq, overrun and frame_err are all 0.
- R2: In 8-bit mode (nine_bit=0) a frame of start bit 0, eight data bits LSB first and stop bit 1 is stored. The byte appears on rx_data, rx_bit9 reads 0, frame_err reads 0 and data_irq goes to 1.
- R3: In 9-bit mode (nine_bit=1) the ninth bit, received after data bit 7, is shown on rx_bit9 next to the byte on rx_data.
- R4: In 9-bit mode with addr_det=1, a frame whose ninth bit is 0 is discarded and leaves data_irq unchanged. A frame whose ninth bit is 1 is stored.
- R5: With addr_det=0, every frame is stored and its ninth bit is presented unchanged, whatever its value.
- R6: A stop bit sampled as 0 stores the word with frame_err=1. The receiver waits for the line to return high before it looks for a new start bit. frame_err always describes the current head word and changes when a pop brings the next word forward.
- R7: A low pulse on rx_in that has ended before the mid-point of the start bit (8 ticks) is a false start. It stores nothing, and the next proper frame is received normally.
- R8: While port_en=0 the receiver stays idle, ignores rx_in and stores nothing.
- R9: While cont_en=0 no frame is received or stored.
- R10: When a frame completes with both buffer entries occupied, overrun is set to 1 and the frame is dropped. Later frames are also dropped while overrun is 1. overrun is cleared only by driving cont_en low.
- R11: data_irq is 1 exactly while the buffer holds at least one word. A one-cycle rd_pop pulse removes the head word, and the next word, or the empty state, shows on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Sample tick at 16x the bit rate |
| rx_in | input | 1 | Serial input line, idle high |
| port_en | input | 1 | Serial port enable |
| cont_en | input | 1 | Continuous-receive enable; low clears overrun |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| addr_det | input | 1 | Address filter enable (9-bit mode only) |
| rd_pop | input | 1 | Removes the buffer head word |
| rx_data | output | 8 | Head word data byte |
| rx_bit9 | output | 1 | Head word ninth bit |
| frame_err | output | 1 | Head word framing error |
| overrun | output | 1 | Sticky overrun flag |
| data_irq | output | 1 | Buffer holds at least one word |

## Verification
The stop bit is sampled at its midpoint, and the accepted word lands in the buffer register on the next clock edge. The buffered outputs are therefore valid well before the stop bit ends. Each frame task holds the stop level for a full bit time and idles a few more cycles before it reads the outputs, so every check falls clearly after the due cycle. A pop takes effect at the clock edge after the strobe is driven, and the bench reads the new head at the following falling edge. Clearing overrun is checked two cycles after cont_en falls.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int WORD_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

    typedef struct packed {
        logic              ferr;
        logic              bit9;
        logic [WORD_W-1:0] data;
    } rx_word_t;

    function automatic logic [3:0] frame_bits(input logic nine);
        return nine ? 4'd9 : 4'd8;
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     tick,
    input  logic     rx,
    input  logic     nine,
    output logic     done,
    output rx_word_t word
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [3:0]        idx;
    logic [WORD_W:0]   shreg;
    logic              cnt_full;
    logic              cnt_half;

    assign cnt_full = (cnt == CW'(OVS - 1));
    assign cnt_half = (cnt == CW'(HALF - 1));

    assign done      = en && tick && (state == RX_STOP) && cnt_full;
    assign word.data = shreg[WORD_W-1:0];
    assign word.bit9 = nine ? shreg[WORD_W] : 1'b0;
    assign word.ferr = ~rx;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
        end else if (tick) begin
            case (state)
                RX_IDLE: begin
                    if (!rx) begin
                        state <= RX_START;
                        cnt   <= '0;
                        shreg <= '0;
                    end
                end
                RX_START: begin
                    if (cnt_half) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= rx ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_full) begin
                        cnt        <= '0;
                        shreg[idx] <= rx;
                        if (idx == frame_bits(nine) - 4'd1) begin
                            state <= RX_STOP;
                        end else begin
                            idx <= idx + 4'd1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt_full) begin
                        cnt   <= '0;
                        state <= rx ? RX_IDLE : RX_BREAK;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_BREAK: begin
                    if (rx) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rx_word_t wdata,
    input  logic     pop,
    output rx_word_t head,
    output logic     empty,
    output logic     full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_word_t      mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_push;
    logic          do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/addr_uart_rx.sv
module addr_uart_rx
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              rx_in,
    input  logic              port_en,
    input  logic              cont_en,
    input  logic              nine_bit,
    input  logic              addr_det,
    input  logic              rd_pop,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              frame_err,
    output logic              overrun,
    output logic              data_irq
);
    logic     frm_done;
    rx_word_t frm_word;
    rx_word_t head;
    logic     buf_empty;
    logic     buf_full;
    logic     wanted;
    logic     store;
    logic     ovr_q;

    uart_rx_sampler #(.OVS(OVS)) u_smp (
        .clk  (clk),
        .rst  (rst),
        .en   (port_en && cont_en),
        .tick (baud_tick),
        .rx   (rx_in),
        .nine (nine_bit),
        .done (frm_done),
        .word (frm_word)
    );

    // address filter: in 9-bit mode with filtering on, keep only ninth-bit-set words
    assign wanted = frm_done && !(nine_bit && addr_det && !frm_word.bit9);
    assign store  = wanted && !ovr_q && !buf_full;

    always_ff @(posedge clk) begin
        if (rst || !cont_en) begin
            ovr_q <= 1'b0;
        end else if (wanted && buf_full) begin
            ovr_q <= 1'b1;
        end
    end

    uart_rx_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .push  (store),
        .wdata (frm_word),
        .pop   (rd_pop),
        .head  (head),
        .empty (buf_empty),
        .full  (buf_full)
    );

    assign rx_data   = head.data;
    assign rx_bit9   = head.bit9;
    assign frame_err = head.ferr && !buf_empty;
    assign overrun   = ovr_q;
    assign data_irq  = !buf_empty;
endmodule

// File: rtl/addr_uart_rx_chk.sv
module addr_uart_rx_chk (
    input logic clk,
    input logic rst,
    input logic port_en,
    input logic cont_en,
    input logic rd_pop,
    input logic frame_err,
    input logic overrun,
    input logic data_irq
);
    assert_ferr_head_R6: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> data_irq);

    assert_port_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!port_en && !data_irq) |=> !data_irq);

    assert_cont_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!cont_en && !data_irq) |=> !data_irq);

    assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (overrun && cont_en) |=> overrun);

    assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (rst)
        !cont_en |=> !overrun);

    assert_ovr_when_full_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(data_irq));

    assert_pop_empty_R11: assert property (@(posedge clk) disable iff (rst)
        (!data_irq && !port_en) |=> !data_irq);
endmodule

bind addr_uart_rx addr_uart_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .port_en   (port_en),
    .cont_en   (cont_en),
    .rd_pop    (rd_pop),
    .frame_err (frame_err),
    .overrun   (overrun),
    .data_irq  (data_irq)
);

// File: tb/sim_addr_uart_rx.sv
module sim_addr_uart_rx;
    localparam int CLK_P   = 10;
    localparam int BIT_CLK = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       port_en = 1'b0;
    logic       cont_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       addr_det = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       frame_err;
    logic       overrun;
    logic       data_irq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) baud_tick <= ~baud_tick;

    addr_uart_rx u0 (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_in(rx_in),
        .port_en(port_en), .cont_en(cont_en), .nine_bit(nine_bit),
        .addr_det(addr_det), .rd_pop(rd_pop), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .frame_err(frame_err), .overrun(overrun),
        .data_irq(data_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [8:0] val, input int nbits, input logic stopv);
        @(negedge clk);
        rx_in = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rx_in = val[i];
            repeat (BIT_CLK) @(negedge clk);
        end
        rx_in = stopv;
        repeat (BIT_CLK) @(negedge clk);
        rx_in = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic pop();
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 irq", data_irq, 0);
        check("R1 overrun", overrun, 0);
        check("R1 frame_err", frame_err, 0);
    endtask

    task automatic t_byte();
        send(9'h0A5, 8, 1'b1);
        check("R2 data", rx_data, 8'hA5);
        check("R2 bit9", rx_bit9, 0);
        check("R2 ferr", frame_err, 0);
        check("R2 irq", data_irq, 1);
        pop();
        check("R11 empty after pop", data_irq, 0);
    endtask

    task automatic t_nine();
        nine_bit = 1'b1;
        send(9'h13C, 9, 1'b1);
        send(9'h05A, 9, 1'b1);
        check("R3 data", rx_data, 8'h3C);
        check("R3 bit9", rx_bit9, 1);
        pop();
        check("R11 next word", rx_data, 8'h5A);
        check("R5 bit9 zero kept", rx_bit9, 0);
        check("R5 irq", data_irq, 1);
        pop();
        check("R11 empty", data_irq, 0);
    endtask

    task automatic t_addr();
        addr_det = 1'b1;
        send(9'h077, 9, 1'b1);
        check("R4 ninth 0 dropped", data_irq, 0);
        send(9'h1C3, 9, 1'b1);
        check("R4 ninth 1 irq", data_irq, 1);
        check("R4 ninth 1 data", rx_data, 8'hC3);
        check("R4 ninth 1 bit9", rx_bit9, 1);
        pop();
        addr_det = 1'b0;
        nine_bit = 1'b0;
    endtask

    task automatic t_ferr();
        send(9'h011, 8, 1'b0);
        send(9'h022, 8, 1'b1);
        check("R6 head data", rx_data, 8'h11);
        check("R6 ferr set", frame_err, 1);
        pop();
        check("R6 next data", rx_data, 8'h22);
        check("R6 ferr follows head", frame_err, 0);
        pop();
    endtask

    task automatic t_false_start();
        @(negedge clk);
        rx_in = 1'b0;
        repeat (8) @(negedge clk);
        rx_in = 1'b1;
        repeat (12 * BIT_CLK) @(negedge clk);
        check("R7 glitch ignored", data_irq, 0);
        send(9'h06E, 8, 1'b1);
        check("R7 next frame data", rx_data, 8'h6E);
        pop();
    endtask

    task automatic t_port_off();
        port_en = 1'b0;
        send(9'h033, 8, 1'b1);
        check("R8 nothing stored", data_irq, 0);
        port_en = 1'b1;
        send(9'h044, 8, 1'b1);
        check("R8 after enable data", rx_data, 8'h44);
        pop();
        check("R8 only one word", data_irq, 0);
    endtask

    task automatic t_cont_off();
        cont_en = 1'b0;
        send(9'h055, 8, 1'b1);
        check("R9 nothing stored", data_irq, 0);
        cont_en = 1'b1;
    endtask

    task automatic t_overrun();
        send(9'h001, 8, 1'b1);
        send(9'h002, 8, 1'b1);
        check("R10 no overrun at two", overrun, 0);
        send(9'h003, 8, 1'b1);
        check("R10 overrun set", overrun, 1);
        check("R10 head kept", rx_data, 8'h01);
        pop();
        send(9'h004, 8, 1'b1);
        check("R10 still sticky", overrun, 1);
        check("R10 second word", rx_data, 8'h02);
        pop();
        check("R10 later frame dropped", data_irq, 0);
        @(negedge clk);
        cont_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 cleared by cont_en", overrun, 0);
        cont_en = 1'b1;
        send(9'h005, 8, 1'b1);
        check("R10 reception resumes", rx_data, 8'h05);
        pop();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        port_en = 1'b1;
        cont_en = 1'b1;
        repeat (4) @(negedge clk);
        t_byte();
        t_nine();
        t_addr();
        t_ferr();
        t_false_start();
        t_port_off();
        t_cont_off();
        t_overrun();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule